// File: doc/BRIEF.md
# Indirect Configuration Access Engine

This block runs one configuration-space access at a time through a target that exposes an address register and a data register. A requester presents bus, device, function, a 12-bit register offset, an access size of 1, 2 or 4 bytes, a read/write flag and write data. The engine packs the target fields into a 32-bit address word and writes it to the address register. It then reads or writes the data register through a simple register-port master.

Reads return the addressed byte lanes, shifted down to bit 0. Writes of a full dword go out directly. Writes of one or two bytes read the dword first, replace only the addressed lanes and write the dword back. An access with an illegal size finishes at once with a bad status. Each request ends with a single-cycle `done` pulse. `busy` holds off new work from acceptance until that pulse.

Top module: `cfg_access_engine`

## Requirements
- R1: The address word has bit 31 set, bus in bits 23:16, device in bits 15:11, function in bits 10:8, offset bits 7:2 in bits 7:2, offset bits 11:8 in bits 27:24, and zeros in bits 30:28 and 1:0.
- R2: In every request, the address register write (`rp_sel`=0) completes before any data register access (`rp_sel`=1).
- R3: A read with `req_size` 1 or 2 returns the fetched dword shifted right by 8×(offset mod 4) and masked to 0xFF or 0xFFFF. Lanes shifted past bit 31 read as zero. Size 4 returns the dword unchanged.
- R4: A write with `req_size`=4 performs no data read and exactly one data write carrying `req_wdata`.
- R5: A write with `req_size` 1 or 2 performs one data read and then one data write. The written dword changes only the addressed lanes at shift 8×(offset mod 4), and lanes past bit 31 are dropped. Bits of `req_wdata` above the access size are ignored.
- R6: A request whose `req_size` is not 1, 2 or 4 ends with `done` and `done_bad` high and makes no port transfer. During that pulse `rsp_rdata` is all ones.
- R7: Each accepted request gives exactly one `done` pulse, one cycle wide. `busy` is high from the cycle after acceptance through `done`. A `req_valid` seen while `busy` is high is ignored.
- R8: While `rp_req` is high and `rp_ack` is low, `rp_req`, `rp_sel`, `rp_we` and `rp_wdata` hold their values.
- R9: After reset, `busy`, `done` and `rp_req` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present; taken when `busy` is low |
| req_write | input | 1 | 1 = write, 0 = read |
| req_bus | input | 8 | Bus number |
| req_dev | input | 5 | Device number |
| req_fn | input | 3 | Function number |
| req_off | input | 12 | Register byte offset |
| req_size | input | 3 | Access size in bytes (1, 2, 4 legal) |
| req_wdata | input | 32 | Write data, right-aligned |
| busy | output | 1 | Request in progress |
| done | output | 1 | One-cycle completion pulse |
| done_bad | output | 1 | Completion with illegal size |
| rsp_rdata | output | 32 | Read result, valid with `done` |
| rp_req | output | 1 | Register-port transfer request |
| rp_we | output | 1 | Register-port write |
| rp_sel | output | 1 | 0 = address register, 1 = data register |
| rp_wdata | output | 32 | Register-port write data |
| rp_ack | input | 1 | Register-port transfer complete |
| rp_rdata | input | 32 | Register-port read data, valid with `rp_ack` |

## Verification
The bench targets accesses whose lanes run past bit 31, such as a 2-byte access at offset 3. A design that widened the shift there would leak or corrupt a neighbouring byte. It also targets extended offsets above 0xFF, where a design that left out the high address field would alias two registers. Partial writes are checked for the read before the write, and full writes for the absence of any read. A wrong choice in either case shows up as a wrong transfer count or a clobbered dword in the modelled target. Illegal sizes, requests made while busy, and a slow target that stalls the handshake are also driven. A faulty design would show a stray data write, a second completion pulse, or a dropped or repeated transfer.

// File: rtl/cfgx_pkg.sv
package cfgx_pkg;
   typedef enum logic [2:0] {
      ST_IDLE,
      ST_ADDR,
      ST_RD,
      ST_WR,
      ST_DONE
   } cfgx_state_e;

   localparam logic [2:0] SZ_BYTE = 3'd1;
   localparam logic [2:0] SZ_HALF = 3'd2;
   localparam logic [2:0] SZ_WORD = 3'd4;
endpackage

// File: rtl/cfgx_addr_pack.sv
module cfgx_addr_pack #(
   parameter int BUS_W = 8,
   parameter int DEV_W = 5,
   parameter int FN_W  = 3,
   parameter int OFF_W = 12
) (
   input  logic [BUS_W-1:0] bus,
   input  logic [DEV_W-1:0] dev,
   input  logic [FN_W-1:0]  fn,
   input  logic [OFF_W-3:0] off_hi,
   output logic [31:0]      aw
);
   localparam int LOW_W = 6;

   if (BUS_W != 8 || DEV_W != 5 || FN_W != 3) begin : g_bad_fields
      $error("cfgx_addr_pack: bus/dev/fn widths must be 8/5/3");
   end
   if (OFF_W != 8 && OFF_W != 12) begin : g_bad_off
      $error("cfgx_addr_pack: OFF_W must be 8 or 12");
   end

   logic [3:0] ext;

   if (OFF_W == 12) begin : g_ext
      assign ext = off_hi[LOW_W+3:LOW_W];
   end else begin : g_no_ext
      assign ext = 4'b0000;
   end

   assign aw = {1'b1, 3'b000, ext, bus, dev, fn, off_hi[LOW_W-1:0], 2'b00};
endmodule

// File: rtl/cfgx_lane_unit.sv
module cfgx_lane_unit #(
   parameter int DATA_W = 32
) (
   input  logic [DATA_W-1:0]           dword,
   input  logic [DATA_W-1:0]           new_data,
   input  logic [$clog2(DATA_W/8)-1:0] off_lo,
   input  logic [2:0]                  size,
   output logic [DATA_W-1:0]           picked,
   output logic [DATA_W-1:0]           merged
);
   import cfgx_pkg::*;
   localparam int SH_W = $clog2(DATA_W/8) + 3;

   if (DATA_W != 32) begin : g_bad_w
      $error("cfgx_lane_unit: DATA_W must be 32");
   end

   logic [SH_W-1:0]   shift;
   logic [DATA_W-1:0] mask;

   assign shift = {off_lo, 3'b000};

   always_comb begin
      case (size)
         SZ_BYTE: mask = DATA_W'(8'hFF);
         SZ_HALF: mask = DATA_W'(16'hFFFF);
         default: mask = '1;
      endcase
   end

   always_comb begin
      if (size == SZ_WORD) begin
         picked = dword;
         merged = new_data;
      end else begin
         picked = (dword >> shift) & mask;
         merged = (dword & ~(mask << shift)) | ((new_data & mask) << shift);
      end
   end
endmodule

// File: rtl/cfgx_seq.sv
module cfgx_seq (
   input  logic clk,
   input  logic rst_n,
   input  logic start,
   input  logic sz_ok,
   input  logic is_wr,
   input  logic is_full,
   input  logic rp_ack,
   output logic rp_req,
   output logic rp_sel,
   output logic rp_we,
   output logic rd_cap,
   output logic busy,
   output logic done
);
   import cfgx_pkg::*;

   cfgx_state_e st, st_nx;

   always_comb begin
      st_nx = st;
      case (st)
         ST_IDLE: if (start) st_nx = sz_ok ? ST_ADDR : ST_DONE;
         ST_ADDR: if (rp_ack) st_nx = (is_wr && is_full) ? ST_WR : ST_RD;
         ST_RD:   if (rp_ack) st_nx = is_wr ? ST_WR : ST_DONE;
         ST_WR:   if (rp_ack) st_nx = ST_DONE;
         default: st_nx = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) st <= ST_IDLE;
      else        st <= st_nx;
   end

   assign rp_req = (st == ST_ADDR) || (st == ST_RD) || (st == ST_WR);
   assign rp_sel = (st == ST_RD) || (st == ST_WR);
   assign rp_we  = (st == ST_ADDR) || (st == ST_WR);
   assign rd_cap = (st == ST_RD) && rp_ack;
   assign busy   = (st != ST_IDLE);
   assign done   = (st == ST_DONE);
endmodule

// File: rtl/cfg_access_engine.sv
module cfg_access_engine #(
   parameter int BUS_W  = 8,
   parameter int DEV_W  = 5,
   parameter int FN_W   = 3,
   parameter int OFF_W  = 12,
   parameter int DATA_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   input  logic              req_write,
   input  logic [BUS_W-1:0]  req_bus,
   input  logic [DEV_W-1:0]  req_dev,
   input  logic [FN_W-1:0]   req_fn,
   input  logic [OFF_W-1:0]  req_off,
   input  logic [2:0]        req_size,
   input  logic [DATA_W-1:0] req_wdata,
   output logic              busy,
   output logic              done,
   output logic              done_bad,
   output logic [DATA_W-1:0] rsp_rdata,
   output logic              rp_req,
   output logic              rp_we,
   output logic              rp_sel,
   output logic [DATA_W-1:0] rp_wdata,
   input  logic              rp_ack,
   input  logic [DATA_W-1:0] rp_rdata
);
   import cfgx_pkg::*;
   localparam int LANE_W = $clog2(DATA_W/8);

   logic              accept, size_ok, rd_cap;
   logic              q_write, q_bad;
   logic [BUS_W-1:0]  q_bus;
   logic [DEV_W-1:0]  q_dev;
   logic [FN_W-1:0]   q_fn;
   logic [OFF_W-1:0]  q_off;
   logic [2:0]        q_size;
   logic [DATA_W-1:0] q_wdata, rd_q, picked, merged;
   logic [31:0]       aw;

   assign accept  = req_valid && !busy;
   assign size_ok = (req_size == SZ_BYTE) || (req_size == SZ_HALF) || (req_size == SZ_WORD);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         q_write <= 1'b0;
         q_bad   <= 1'b0;
         q_bus   <= '0;
         q_dev   <= '0;
         q_fn    <= '0;
         q_off   <= '0;
         q_size  <= '0;
         q_wdata <= '0;
      end else if (accept) begin
         q_write <= req_write;
         q_bad   <= !size_ok;
         q_bus   <= req_bus;
         q_dev   <= req_dev;
         q_fn    <= req_fn;
         q_off   <= req_off;
         q_size  <= req_size;
         q_wdata <= req_wdata;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n)      rd_q <= '0;
      else if (rd_cap) rd_q <= rp_rdata;
   end

   cfgx_seq u_seq (
      .clk     (clk),
      .rst_n   (rst_n),
      .start   (accept),
      .sz_ok   (size_ok),
      .is_wr   (q_write),
      .is_full (q_size == SZ_WORD),
      .rp_ack  (rp_ack),
      .rp_req  (rp_req),
      .rp_sel  (rp_sel),
      .rp_we   (rp_we),
      .rd_cap  (rd_cap),
      .busy    (busy),
      .done    (done)
   );

   cfgx_addr_pack #(
      .BUS_W (BUS_W),
      .DEV_W (DEV_W),
      .FN_W  (FN_W),
      .OFF_W (OFF_W)
   ) u_pack (
      .bus    (q_bus),
      .dev    (q_dev),
      .fn     (q_fn),
      .off_hi (q_off[OFF_W-1:2]),
      .aw     (aw)
   );

   cfgx_lane_unit #(
      .DATA_W (DATA_W)
   ) u_lane (
      .dword    (rd_q),
      .new_data (q_wdata),
      .off_lo   (q_off[LANE_W-1:0]),
      .size     (q_size),
      .picked   (picked),
      .merged   (merged)
   );

   assign rp_wdata = rp_sel ? merged : DATA_W'(aw);
   assign done_bad = done && q_bad;

   always_comb begin
      if (!done)        rsp_rdata = '0;
      else if (q_bad)   rsp_rdata = '1;
      else if (q_write) rsp_rdata = '0;
      else              rsp_rdata = picked;
   end
endmodule

// File: rtl/cfgx_checker.sv
module cfgx_checker (
   input logic        clk,
   input logic        rst_n,
   input logic        req_valid,
   input logic        req_write,
   input logic [2:0]  req_size,
   input logic        busy,
   input logic        done,
   input logic        done_bad,
   input logic        rp_req,
   input logic        rp_we,
   input logic        rp_sel,
   input logic [31:0] rp_wdata,
   input logic        rp_ack
);
   logic       a_seen, d_rd, d_wr, c_wr;
   logic [2:0] c_sz;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         a_seen <= 1'b0;
         d_rd   <= 1'b0;
         d_wr   <= 1'b0;
         c_wr   <= 1'b0;
         c_sz   <= 3'd0;
      end else if (req_valid && !busy) begin
         a_seen <= 1'b0;
         d_rd   <= 1'b0;
         d_wr   <= 1'b0;
         c_wr   <= req_write;
         c_sz   <= req_size;
      end else if (rp_req && rp_ack) begin
         if (!rp_sel)    a_seen <= 1'b1;
         else if (rp_we) d_wr   <= 1'b1;
         else            d_rd   <= 1'b1;
      end
   end

   assert_addr_word_R1: assert property (@(posedge clk) disable iff (!rst_n)
      rp_req && !rp_sel |-> rp_we && rp_wdata[31] && rp_wdata[30:28] == 3'b000 && rp_wdata[1:0] == 2'b00);

   assert_addr_first_R2: assert property (@(posedge clk) disable iff (!rst_n)
      rp_req && rp_sel |-> a_seen);

   assert_full_write_R4: assert property (@(posedge clk) disable iff (!rst_n)
      done && c_wr && c_sz == 3'd4 |-> d_wr && !d_rd);

   assert_partial_rmw_R5: assert property (@(posedge clk) disable iff (!rst_n)
      done && c_wr && (c_sz == 3'd1 || c_sz == 3'd2) |-> d_rd && d_wr);

   assert_bad_quiet_R6: assert property (@(posedge clk) disable iff (!rst_n)
      done_bad |-> done && !a_seen && !d_rd && !d_wr);

   assert_done_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   assert_busy_cover_R7: assert property (@(posedge clk) disable iff (!rst_n)
      rp_req || done |-> busy);

   assert_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
      rp_req && !rp_ack |=> rp_req && $stable(rp_sel) && $stable(rp_we) && $stable(rp_wdata));
endmodule

bind cfg_access_engine cfgx_checker u_chk (.*);

// File: tb/test_cfg_access_engine.sv
module test_cfg_access_engine;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_valid = 1'b0, req_write = 1'b0;
   logic [7:0]  req_bus = '0;
   logic [4:0]  req_dev = '0;
   logic [2:0]  req_fn = '0;
   logic [11:0] req_off = '0;
   logic [2:0]  req_size = '0;
   logic [31:0] req_wdata = '0;
   logic        busy, done, done_bad;
   logic [31:0] rsp_rdata, rp_wdata;
   logic        rp_req, rp_we, rp_sel;
   logic        rp_ack = 1'b0;
   logic [31:0] rp_rdata = '0;

   always #5 clk = ~clk;

   cfg_access_engine i_cfg_access_engine (.*);

   int total = 0, bad = 0;

   // target model and transfer log
   logic [31:0] tmem [64];
   logic [31:0] cur_aw = '0, last_aw = '0;
   int n_aw = 0, n_drd = 0, n_dwr = 0, n_done = 0, order_bad = 0;
   int lat = 0, wcnt = 0;

   function automatic logic [5:0] idx_of(input logic [31:0] a);
      return {a[25:24], a[5:2]};
   endfunction

   always @(posedge clk) begin
      if (done) n_done <= n_done + 1;
      if (rp_ack) rp_ack <= 1'b0;
      else if (rp_req) begin
         if (wcnt < lat) wcnt <= wcnt + 1;
         else begin
            wcnt   <= 0;
            rp_ack <= 1'b1;
            if (!rp_sel) begin
               n_aw    <= n_aw + 1;
               cur_aw  <= rp_wdata;
               last_aw <= rp_wdata;
            end else begin
               if (n_aw == 0) order_bad <= order_bad + 1;
               if (rp_we) begin
                  n_dwr <= n_dwr + 1;
                  tmem[idx_of(cur_aw)] <= rp_wdata;
               end else begin
                  n_drd    <= n_drd + 1;
                  rp_rdata <= tmem[idx_of(cur_aw)];
               end
            end
         end
      end
   end

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic clr_log();
      n_aw = 0; n_drd = 0; n_dwr = 0; n_done = 0; order_bad = 0;
   endtask

   typedef struct packed {
      logic        wr;
      logic [7:0]  bus;
      logic [4:0]  dev;
      logic [2:0]  fn;
      logic [11:0] off;
      logic [2:0]  sz;
      logic [31:0] wd;
      logic [31:0] pre;
   } vec_t;

   localparam vec_t VECS [8] = '{
      '{1'b0, 8'h00, 5'd0,  3'd0, 12'h000, 3'd4, 32'h0,        32'h11223344},
      '{1'b0, 8'h03, 5'd5,  3'd2, 12'h00D, 3'd1, 32'h0,        32'hA1B2C3D4},
      '{1'b0, 8'h80, 5'd31, 3'd7, 12'h102, 3'd2, 32'h0,        32'hA1B2C3D4},
      '{1'b0, 8'h10, 5'd9,  3'd4, 12'h0F3, 3'd2, 32'h0,        32'hA1B2C3D4},
      '{1'b1, 8'h01, 5'd2,  3'd1, 12'h804, 3'd4, 32'hCAFEF00D, 32'h0},
      '{1'b1, 8'h55, 5'd17, 3'd3, 12'h205, 3'd1, 32'hFFFFFF5A, 32'h11223344},
      '{1'b1, 8'hFE, 5'd1,  3'd6, 12'h312, 3'd2, 32'hABCDBEEF, 32'h11223344},
      '{1'b1, 8'h7F, 5'd30, 3'd5, 12'hF0B, 3'd2, 32'h0000BEEF, 32'h11223344}
   };

   function automatic logic [31:0] exp_aw(input vec_t v);
      return {1'b1, 3'b000, v.off[11:8], v.bus, v.dev, v.fn, v.off[7:2], 2'b00};
   endfunction

   function automatic logic [31:0] szmask(input logic [2:0] s);
      return (s == 3'd1) ? 32'hFF : (s == 3'd2) ? 32'hFFFF : 32'hFFFF_FFFF;
   endfunction

   task automatic run_req(input vec_t v, output logic got_bad, output logic [31:0] got_rd);
      int guard = 0;
      clr_log();
      @(negedge clk);
      req_valid = 1'b1; req_write = v.wr; req_bus = v.bus; req_dev = v.dev;
      req_fn = v.fn; req_off = v.off; req_size = v.sz; req_wdata = v.wd;
      @(negedge clk);
      req_valid = 1'b0;
      while (!done && guard < 500) begin
         @(negedge clk);
         guard++;
      end
      got_bad = done_bad;
      got_rd  = rsp_rdata;
      @(negedge clk);
   endtask

   initial begin : watchdog
      repeat (100000) @(posedge clk);
      bad++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      logic        gb;
      logic [31:0] gr, sh, m, e;
      for (int i = 0; i < 64; i++) tmem[i] = 32'h0;
      repeat (3) @(negedge clk);
      // R9 reset state
      chk("R9 busy", {31'b0, busy}, 32'd0);
      chk("R9 done", {31'b0, done}, 32'd0);
      chk("R9 rp_req", {31'b0, rp_req}, 32'd0);
      rst_n = 1'b1;
      @(negedge clk);

      for (int k = 0; k < 8; k++) begin
         vec_t v = VECS[k];
         tmem[idx_of(exp_aw(v))] = v.pre;
         run_req(v, gb, gr);
         chk($sformatf("R1 addr word v%0d", k), last_aw, exp_aw(v));
         chk($sformatf("R2 order v%0d", k), order_bad, 0);
         chk($sformatf("R7 one done v%0d", k), n_done, 1);
         chk($sformatf("R6 not bad v%0d", k), {31'b0, gb}, 32'd0);
         sh = {27'b0, v.off[1:0], 3'b000};
         m  = szmask(v.sz);
         if (!v.wr) begin
            e = (v.sz == 3'd4) ? v.pre : ((v.pre >> sh) & m);
            chk($sformatf("R3 read data v%0d", k), gr, e);
            chk($sformatf("R3 no write v%0d", k), n_dwr, 0);
         end else if (v.sz == 3'd4) begin
            chk($sformatf("R4 no read v%0d", k), n_drd, 0);
            chk($sformatf("R4 one write v%0d", k), n_dwr, 1);
            chk($sformatf("R4 dword v%0d", k), tmem[idx_of(exp_aw(v))], v.wd);
         end else begin
            e = (v.pre & ~(m << sh)) | ((v.wd & m) << sh);
            chk($sformatf("R5 reads v%0d", k), n_drd, 1);
            chk($sformatf("R5 writes v%0d", k), n_dwr, 1);
            chk($sformatf("R5 merged v%0d", k), tmem[idx_of(exp_aw(v))], e);
         end
      end

      // R6 illegal sizes, write and read
      begin
         vec_t v = '{1'b1, 8'h02, 5'd3, 3'd0, 12'h010, 3'd3, 32'hDEADBEEF, 32'h0};
         tmem[idx_of(exp_aw(v))] = 32'h5555AAAA;
         run_req(v, gb, gr);
         chk("R6 bad flag write", {31'b0, gb}, 32'd1);
         chk("R6 no transfers write", n_aw + n_drd + n_dwr, 0);
         chk("R6 target kept", tmem[idx_of(exp_aw(v))], 32'h5555AAAA);
         chk("R6 rdata ones", gr, 32'hFFFF_FFFF);
         v.wr = 1'b0; v.sz = 3'd0;
         run_req(v, gb, gr);
         chk("R6 bad flag read", {31'b0, gb}, 32'd1);
         chk("R6 no transfers read", n_aw + n_drd + n_dwr, 0);
      end

      // R7 request while busy is ignored
      begin
         int guard = 0;
         vec_t v = '{1'b0, 8'h04, 5'd4, 3'd1, 12'h020, 3'd4, 32'h0, 32'h0BADF00D};
         vec_t w = '{1'b1, 8'h04, 5'd4, 3'd1, 12'h024, 3'd4, 32'h12345678, 32'h0};
         tmem[idx_of(exp_aw(v))] = v.pre;
         tmem[idx_of(exp_aw(w))] = 32'h87654321;
         clr_log();
         @(negedge clk);
         req_valid = 1'b1; req_write = v.wr; req_bus = v.bus; req_dev = v.dev;
         req_fn = v.fn; req_off = v.off; req_size = v.sz; req_wdata = v.wd;
         @(negedge clk);
         req_write = w.wr; req_off = w.off; req_wdata = w.wd;
         while (!done && guard < 500) begin
            @(negedge clk);
            guard++;
         end
         gr = rsp_rdata;
         req_valid = 1'b0;
         repeat (3) @(negedge clk);
         chk("R7 first result", gr, 32'h0BADF00D);
         chk("R7 single done", n_done, 1);
         chk("R7 no stray write", n_dwr, 0);
         chk("R7 other dword kept", tmem[idx_of(exp_aw(w))], 32'h87654321);
      end

      // R8 slow target, partial write still single transfers
      begin
         vec_t v = '{1'b1, 8'h09, 5'd12, 3'd2, 12'h442, 3'd1, 32'h000000C3, 32'hF0F0F0F0};
         lat = 3;
         tmem[idx_of(exp_aw(v))] = v.pre;
         run_req(v, gb, gr);
         lat = 0;
         chk("R8 one addr write", n_aw, 1);
         chk("R8 one read one write", n_drd * 16 + n_dwr, 17);
         chk("R8 merged", tmem[idx_of(exp_aw(v))], 32'hF0C3F0F0);
      end

      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule